// File: doc/BRIEF.md
# Clock Frequency Deviation Monitor

This block watches a set of candidate timing sources and reports any whose frequency has drifted too far from the timing reference now in use. Each candidate and the reference arrive as single-cycle edge strobes that are already synchronous to the system clock. A gate window is N reference edges long. Within each window the block counts the edges of every candidate. It then works out the candidate's offset in parts per billion and compares that offset with a programmable threshold.

A candidate that goes over the threshold gets its abnormal flag set. The flag is sticky: it stays set after the candidate comes back within range. Only a per-candidate recover pulse clears it. Selection logic downstream reads the abnormal vector and can keep flagged sources out of the reference election.

Detection is off after reset. Turning it off at any time clears every flag and stops measurement. If the reference stops being valid part way through a window, that window is thrown away.

Top module: `fdm_monitor`

## Requirements
- R1: After reset all abnormal flags read 0, detection is disabled and the threshold register holds 4600 ppb.
- R2: When detection is enabled, the reference is valid and no window is running, a reference strobe opens a window. The window closes on the GATE_EDGES-th reference strobe after the opening one, and that same closing strobe opens the next window at once. Candidate strobes are counted from the cycle after the opening strobe up to and including the closing cycle.
- R3: At the clock edge of the closing strobe, a candidate's flag sets when |count - GATE_EDGES| * 10^9 > threshold * GATE_EDGES. When the two sides are equal, the flag does not set.
- R4: The test in R3 applies in the same way to candidates that run slow (fewer edges) and candidates that run fast (more edges).
- R5: A set flag stays set through later windows whose deviation is within the threshold.
- R6: A pulse on recover[i] clears flag i at the next clock edge and leaves every other flag unchanged.
- R7: When recover[i] is high in the same cycle as a closing strobe whose result for candidate i exceeds the threshold, flag i ends up set.
- R8: If ref_valid is low in any cycle while a window is running, the window ends with no change to any flag. A new window starts only on a later opening strobe.
- R9: While det_enable is low, every flag reads 0 from the next clock edge on and no window runs.
- R10: A cycle with thr_wr high loads thr_wdata into the threshold register, and later evaluations use that value. The value is kept while detection is disabled.
- R11: Each candidate's flag depends only on that candidate's own edge count and recover pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_enable | input | 1 | Deviation detection enable |
| thr_wr | input | 1 | Load strobe for the threshold register |
| thr_wdata | input | THR_W | Threshold in parts per billion |
| ref_strobe | input | 1 | One-cycle pulse per reference clock edge |
| ref_valid | input | 1 | Reference signal is present and usable |
| cand_strobe | input | NUM_SRC | One-cycle pulse per edge of each candidate |
| recover | input | NUM_SRC | Per-candidate pulse that returns the flag to normal |
| abnormal | output | NUM_SRC | Sticky per-candidate deviation flag |

## Verification
The bench places candidate counts right at the threshold boundary, one edge on each side, in both the slow and the fast direction. A design using >= instead of > would flag the equal case, and a design taking an unsigned difference would miss slow sources. It issues a recover pulse in the same cycle as an exceeding close, so a design where recover wins would show a cleared flag. It also drops the reference valid signal in the middle of a window that has a large surplus of candidate edges. A design that kept counting, or that evaluated the partial window, would raise flags that the scoreboard does not expect. Sticky behaviour, clearing on disable and the threshold surviving a disable are checked through windows that follow these cases.

// File: rtl/fdm_pkg.sv
package fdm_pkg;

  localparam longint unsigned PPB_SCALE = 64'd1_000_000_000;

  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_RUN  = 1'b1
  } gate_state_e;

  // Allowed deviation, pre-multiplied by the gate length (no division).
  function automatic logic [63:0] scaled_limit(input logic [31:0] thr_ppb,
                                               input logic [31:0] gate_len);
    return 64'(thr_ppb) * 64'(gate_len);
  endfunction

  // Edge-count error scaled to the same units as scaled_limit.
  function automatic logic [63:0] scaled_error(input logic [31:0] edge_cnt,
                                               input logic [31:0] gate_len);
    logic [31:0] diff;
    diff = (edge_cnt >= gate_len) ? (edge_cnt - gate_len) : (gate_len - edge_cnt);
    return 64'(diff) * PPB_SCALE;
  endfunction

  function automatic logic deviation_exceeds(input logic [31:0] edge_cnt,
                                             input logic [31:0] gate_len,
                                             input logic [31:0] thr_ppb);
    return scaled_error(edge_cnt, gate_len) > scaled_limit(thr_ppb, gate_len);
  endfunction

endpackage

// File: rtl/fdm_gate_timer.sv
module fdm_gate_timer #(
  parameter int GATE_EDGES = 1_000_000,
  parameter int RCNT_W     = $clog2(GATE_EDGES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ref_strobe,
  input  logic ref_valid,
  output logic win_active,
  output logic win_restart,
  output logic gate_done
);
  import fdm_pkg::*;

  localparam logic [RCNT_W-1:0] LAST_EDGE = RCNT_W'(GATE_EDGES - 1);

  gate_state_e        state_q;
  logic [RCNT_W-1:0]  rcnt_q;
  logic               gate_abort;
  logic               gate_start;

  assign win_active  = (state_q == GATE_RUN);
  assign gate_abort  = win_active && (!enable || !ref_valid);
  assign gate_start  = !win_active && enable && ref_valid && ref_strobe;
  assign gate_done   = win_active && enable && ref_valid && ref_strobe &&
                       (rcnt_q == LAST_EDGE);
  assign win_restart = gate_start || gate_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_IDLE;
      rcnt_q  <= '0;
    end else if (gate_abort) begin
      state_q <= GATE_IDLE;
      rcnt_q  <= '0;
    end else if (gate_start) begin
      state_q <= GATE_RUN;
      rcnt_q  <= '0;
    end else if (win_active && ref_strobe) begin
      rcnt_q  <= gate_done ? '0 : rcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/fdm_edge_counter.sv
module fdm_edge_counter #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             count_en,
  input  logic             strobe,
  output logic [CNT_W-1:0] cnt_total
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  // Count including the current cycle's strobe, saturating at all ones.
  assign sum       = {1'b0, cnt_q} + {{CNT_W{1'b0}}, (count_en & strobe)};
  assign cnt_total = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (count_en) cnt_q <= cnt_total;
  end

endmodule

// File: rtl/fdm_status_cell.sv
module fdm_status_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic set_req,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (!enable) flag <= 1'b0;
    else if (set_req) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end
endmodule

// File: rtl/fdm_monitor.sv
module fdm_monitor #(
  parameter int NUM_SRC         = 4,
  parameter int GATE_EDGES      = 1_000_000,
  parameter int THR_W           = 32,
  parameter int DEFAULT_THR_PPB = 4600
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               det_enable,
  input  logic               thr_wr,
  input  logic [THR_W-1:0]   thr_wdata,
  input  logic               ref_strobe,
  input  logic               ref_valid,
  input  logic [NUM_SRC-1:0] cand_strobe,
  input  logic [NUM_SRC-1:0] recover,
  output logic [NUM_SRC-1:0] abnormal
);
  import fdm_pkg::*;

  localparam int RCNT_W = $clog2(GATE_EDGES);
  localparam int CNT_W  = RCNT_W + 2;

  logic [THR_W-1:0]   thr_q;
  logic               win_active;
  logic               win_restart;
  logic               gate_done;
  logic [NUM_SRC-1:0] exceed_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= THR_W'(DEFAULT_THR_PPB);
    else if (thr_wr) thr_q <= thr_wdata;
  end

  fdm_gate_timer #(
    .GATE_EDGES (GATE_EDGES),
    .RCNT_W     (RCNT_W)
  ) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (det_enable),
    .ref_strobe  (ref_strobe),
    .ref_valid   (ref_valid),
    .win_active  (win_active),
    .win_restart (win_restart),
    .gate_done   (gate_done)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [CNT_W-1:0] total;

    fdm_edge_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (win_restart),
      .count_en  (win_active),
      .strobe    (cand_strobe[i]),
      .cnt_total (total)
    );

    assign exceed_vec[i] = deviation_exceeds(32'(total), 32'(GATE_EDGES), 32'(thr_q));

    fdm_status_cell u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (det_enable),
      .set_req (gate_done && exceed_vec[i]),
      .clr_req (recover[i]),
      .flag    (abnormal[i])
    );
  end

endmodule

// File: rtl/fdm_checker.sv
module fdm_checker #(
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               det_enable,
  input logic               ref_strobe,
  input logic               ref_valid,
  input logic [NUM_SRC-1:0] recover,
  input logic [NUM_SRC-1:0] abnormal,
  input logic               gate_done,
  input logic               win_active,
  input logic [NUM_SRC-1:0] exceed_vec
);

  p_clear_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !det_enable |=> (abnormal == '0));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(det_enable) |-> (($past(abnormal) & ~$past(recover) & ~abnormal) == '0));

  p_set_at_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((abnormal & ~$past(abnormal)) != '0) |-> $past(gate_done));

  p_exceed_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_done |=> (($past(exceed_vec) & ~abnormal) == '0));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |=> !win_active);

  p_close_on_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_done |-> (ref_strobe && ref_valid && det_enable && win_active));

endmodule

bind fdm_monitor fdm_checker #(.NUM_SRC(NUM_SRC)) u_fdm_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .det_enable (det_enable),
  .ref_strobe (ref_strobe),
  .ref_valid  (ref_valid),
  .recover    (recover),
  .abnormal   (abnormal),
  .gate_done  (gate_done),
  .win_active (win_active),
  .exceed_vec (exceed_vec)
);

// File: tb/fdm_monitor_test.sv
`timescale 1ns/1ps
module fdm_monitor_test;
  localparam int NS = 4;
  localparam int N  = 200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          det_enable = 1'b0;
  logic          thr_wr = 1'b0;
  logic [31:0]   thr_wdata = '0;
  logic          ref_strobe = 1'b0;
  logic          ref_valid = 1'b1;
  logic [NS-1:0] cand_strobe = '0;
  logic [NS-1:0] recover = '0;
  logic [NS-1:0] abnormal;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit chk_req = 0;
  bit model_en = 0;
  longint thr_model = 4600;
  logic [NS-1:0] model_stat = '0;
  logic [NS-1:0] sb_q[$];

  always #2.5 clk = ~clk;

  fdm_monitor #(.NUM_SRC(NS), .GATE_EDGES(N)) uut (
    .clk(clk), .rst_n(rst_n), .det_enable(det_enable), .thr_wr(thr_wr),
    .thr_wdata(thr_wdata), .ref_strobe(ref_strobe), .ref_valid(ref_valid),
    .cand_strobe(cand_strobe), .recover(recover), .abnormal(abnormal)
  );

  task automatic check(input string req, input logic [NS-1:0] act, input logic [NS-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s abnormal=%b expected=%b", req, act, expv);
    end
  endtask

  // Scoreboard monitor: compares just after the edge that evaluates a window.
  initial forever begin
    @(posedge clk);
    #1;
    if (chk_req) begin
      logic [NS-1:0] e;
      e = sb_q.pop_front();
      check("R2/R3 window result", abnormal, e);
    end
  end

  task automatic drive_periods(input int dv[NS], input int nper, input bit close_win,
                               input logic [NS-1:0] rec);
    for (int k = 1; k <= nper; k++) begin
      @(negedge clk); ref_strobe = 0; cand_strobe = '0; recover = '0; chk_req = 0;
      @(negedge clk);
      for (int i = 0; i < NS; i++) cand_strobe[i] = (dv[i] >= k);
      @(negedge clk); cand_strobe = '0;
      @(negedge clk);
      ref_strobe = 1;
      for (int i = 0; i < NS; i++) cand_strobe[i] = !(-dv[i] >= k);
      if (close_win && k == nper) begin
        logic [NS-1:0] exc;
        for (int i = 0; i < NS; i++) begin
          real dev_ppb;
          dev_ppb = real'((dv[i] < 0) ? -dv[i] : dv[i]) * 1.0e9 / real'(N);
          exc[i] = model_en && (dev_ppb > real'(thr_model));
        end
        recover = rec;
        model_stat = model_en ? ((model_stat & ~rec) | exc) : '0;
        sb_q.push_back(model_stat);
        chk_req = 1;
      end
    end
    @(negedge clk); ref_strobe = 0; cand_strobe = '0; recover = '0; chk_req = 0;
  endtask

  task automatic run_window(input int dv[NS], input logic [NS-1:0] rec);
    drive_periods(dv, N, 1'b1, rec);
  endtask

  task automatic open_gate();
    @(negedge clk); ref_strobe = 1; cand_strobe = '0;
    @(negedge clk); ref_strobe = 0;
  endtask

  task automatic pulse_recover(input logic [NS-1:0] m);
    @(negedge clk); recover = m;
    @(negedge clk); recover = '0;
    model_stat = model_stat & ~m;
  endtask

  task automatic write_thr(input longint v);
    @(negedge clk); thr_wr = 1; thr_wdata = 32'(v);
    @(negedge clk); thr_wr = 0;
    thr_model = v;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset flags clear", abnormal, '0);

    // R9: disabled, large deviations must not flag
    open_gate();
    run_window('{5, 5, -5, -5}, '0);
    check("R9 disabled no flags", abnormal, '0);

    // R1 default threshold 4600 ppb: one edge off is already too much at N=200
    @(negedge clk); det_enable = 1; model_en = 1;
    open_gate();
    run_window('{0, 1, -1, 0}, '0);   // R3 R4 R11 expect 0110

    // R6 recover one at a time
    pulse_recover(4'b0010);
    @(negedge clk);
    check("R6 recover cand1 only", abnormal, 4'b0100);
    pulse_recover(4'b0100);
    @(negedge clk);
    check("R6 recover cand2", abnormal, 4'b0000);

    // R10 threshold 10,000,000 ppb: 2 edges equal limit, 3 edges exceed
    write_thr(10_000_000);
    run_window('{2, 3, -3, -2}, '0);  // R3 boundary, R4 slow and fast
    check("R4 slow/fast boundary", abnormal, 4'b0110);

    // R5 sticky through in-range window
    run_window('{0, 0, 0, 0}, '0);
    check("R5 sticky flags", abnormal, 4'b0110);

    // R7 recover at close: exceed wins on cand1, cand2 clears
    run_window('{0, 3, 0, 0}, 4'b0110);
    check("R7 exceed beats recover", abnormal, 4'b0010);

    // R8 abort: surplus edges then reference drop, no change
    drive_periods('{50, 0, 0, 50}, 50, 1'b0, '0);
    @(negedge clk); ref_valid = 0;
    @(negedge clk); ref_valid = 1;
    @(negedge clk);
    check("R8 abort no change", abnormal, 4'b0010);
    open_gate();
    run_window('{0, 0, 0, 0}, '0);
    check("R8 fresh window after abort", abnormal, 4'b0010);

    // R9 disable clears flags
    @(negedge clk); det_enable = 0; model_en = 0; model_stat = '0;
    @(negedge clk);
    check("R9 disable clears", abnormal, '0);
    @(negedge clk); det_enable = 1; model_en = 1;
    @(negedge clk);
    check("R9 re-enable stays clear", abnormal, '0);
    open_gate();
    run_window('{0, 0, 1, 2}, '0);
    check("R10 threshold kept across disable", abnormal, '0);
    run_window('{0, 0, 0, 3}, '0);
    check("R11 only cand3 flags", abnormal, 4'b1000);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule